// File: doc/BRIEF.md
# Multi-format stereo serial audio port

This block receives and transmits stereo PCM on three serial data lanes. All lanes share one bit clock and one frame clock, and both clocks come from outside the block. The block samples the bit clock, the frame clock and the lane inputs into its own system clock domain. It then follows the frame and tracks which slot within the channel half comes next.

The receive side turns each lane's serial words into signed 24-bit left and right samples. Words shorter than 24 bits are left-aligned and their low bits are zero. All lanes present their samples together with one strobe per frame.

The transmit side takes parallel left and right samples per lane and sends the top bits of each, MSB first. It uses the same alignment, word length and frame size as the receive side.

Three configuration inputs select the settings, and they are held steady while the block runs:
- the alignment: I2S, left-justified or right-justified;
- the word length: 16, 18, 20 or 24 bits;
- the frame size: 32 or 64 bit clocks.

Top module: `sap_port`

## Requirements
- R1: While reset is asserted and after it is released, before any frame-clock transition, `rx_valid_o` is 0, all `sdout_o` lines are 0 and all received samples read 0.
- R2: With `cfg_fmt`=1 (left-justified; code 3 behaves the same), frame clock high marks the left channel and the word's MSB occupies the first bit slot after the frame-clock transition.
- R3: With `cfg_fmt`=0 (I2S), frame clock low marks the left channel and the MSB occupies the second bit slot after the transition. For a 16-bit word in a 32-slot frame, the word's LSB therefore falls in the first slot of the following half.
- R4: With `cfg_fmt`=2 (right-justified), frame clock high marks the left channel and the word's LSB occupies the last bit slot before the next frame-clock transition.
- R5: `cfg_wlen` codes 0, 1, 2 and 3 select 16, 18, 20 and 24-bit words. A received word of N bits appears in bits 23 down to 24-N of its sample, and the bits below are zero.
- R6: `cfg_wide`=1 selects 64 bit clocks per frame and `cfg_wide`=0 selects 32. With 32, the word length is 16 bits whatever `cfg_wlen` holds.
- R7: Each output lane sends bits 23 down to 24-N of its transmit sample MSB first, left channel first, in the selected alignment. Every slot outside the active word carries 0.
- R8: Input bits in slots outside the active word have no effect on the received samples.
- R9: `rx_valid_o` is a one-cycle pulse, raised once per frame after the right-channel word is complete, with that frame's left and right samples on the outputs in the same cycle. The first pulse after reset needs a complete left word first.
- R10: The three lanes are independent. Each lane's received samples depend only on its own input line, and each output line depends only on its own transmit samples.
- R11: Input data is captured at bit-clock rising edges. Output data changes only after bit-clock falling edges and stays stable across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Alignment: 0 I2S, 1 left-justified, 2 right-justified |
| cfg_wlen | input | 2 | Word length code: 16/18/20/24 bits |
| cfg_wide | input | 1 | 1: 64 bit clocks per frame, 0: 32 |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame clock |
| sdin_i | input | LANES | Serial data inputs |
| tx_left_i | input | 24*LANES | Left transmit samples, lane k in bits 24k+23..24k |
| tx_right_i | input | 24*LANES | Right transmit samples, same packing |
| sdout_o | output | LANES | Serial data outputs |
| rx_left_o | output | 24*LANES | Received left samples, same packing |
| rx_right_o | output | 24*LANES | Received right samples, same packing |
| rx_valid_o | output | 1 | One-cycle strobe for a complete received frame |

## Verification
The bench builds the port with its default three lanes and two synchronizer stages, and drives a bit clock twelve system clocks long. Every combination of the three alignments and four word lengths is run in 64-slot frames. Each alignment is also run in 32-slot frames with a non-16 word-length code.

Together these runs reach the right-justified window offset for every word length and the I2S word that spills into the next half. Random fill in the unused input slots and distinct random samples per lane expose slot-window errors and lane cross-talk.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int SAMPLE_W = 24;
  localparam int POS_W    = 6;
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
    logic       last;
  } slot_t;

  // Active word length in bits.
  function automatic logic [4:0] word_bits(input logic [1:0] wl, input logic wide);
    logic [4:0] n;
    if (!wide) n = 5'd16;
    else begin
      case (wl)
        2'd0:    n = 5'd16;
        2'd1:    n = 5'd18;
        2'd2:    n = 5'd20;
        default: n = 5'd24;
      endcase
    end
    return n;
  endfunction

  function automatic logic [POS_W-1:0] half_slots(input logic wide);
    return wide ? POS_W'(32) : POS_W'(16);
  endfunction

  // First slot of the word within its (reference-aligned) half.
  function automatic logic [POS_W-1:0] word_off(input logic [1:0] fmt, input logic wide,
                                                 input logic [4:0] n);
    return (fmt == FMT_RJ) ? half_slots(wide) - {1'b0, n} : '0;
  endfunction

  function automatic slot_t locate(input logic [POS_W-1:0] pos, input logic [POS_W-1:0] off,
                                   input logic [4:0] n);
    slot_t s;
    logic [POS_W-1:0] rel;
    rel    = pos - off;
    s.hit  = (pos >= off) && (rel < {1'b0, n});
    s.idx  = rel[4:0];
    s.last = s.hit && (rel == ({1'b0, n} - 1'b1));
    return s;
  endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sap_framer.sv
module sap_framer
  import sap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bck_s,
  input  logic       lr_s,
  input  logic [1:0] fmt,
  input  logic [1:0] wlen,
  input  logic       wide,
  output logic       rise_o,
  output logic       fall_o,
  output logic       hit_o,
  output logic [4:0] idx_o,
  output logic       last_o,
  output logic       left_o,
  output logic       clr_o,
  output logic       load_o,
  output logic       commit_o,
  output logic       valid_o
);
  logic             bck_q, bck_d;
  logic             lr_prev_q, lr_prev_d;
  logic             ref_q, ref_d;
  logic             seen_q, seen_d;
  logic             valid_q, valid_d;
  logic [POS_W-1:0] pos_q, pos_d;

  logic             i2s, cur_ref, cur_left, commit;
  logic [4:0]       nbits;
  logic [POS_W-1:0] off, pos_inc, cur_pos;
  slot_t            slot;

  always_comb begin
    rise_o   = bck_s & ~bck_q;
    fall_o   = ~bck_s & bck_q;
    i2s      = (fmt == FMT_I2S);
    nbits    = word_bits(wlen, wide);
    off      = word_off(fmt, wide, nbits);
    pos_inc  = (pos_q == POS_IDLE) ? POS_IDLE : pos_q + 1'b1;
    // I2S is framed on the frame clock delayed by one bit slot.
    cur_ref  = i2s ? lr_prev_q : lr_s;
    cur_pos  = (cur_ref != ref_q) ? '0 : pos_inc;
    cur_left = i2s ? ~cur_ref : cur_ref;
    slot     = locate(cur_pos, off, nbits);
    commit   = rise_o & slot.last & ~cur_left & seen_q;
  end

  always_comb begin
    bck_d     = bck_s;
    lr_prev_d = lr_prev_q;
    ref_d     = ref_q;
    pos_d     = pos_q;
    seen_d    = seen_q;
    valid_d   = commit;
    if (rise_o) begin
      lr_prev_d = lr_s;
      ref_d     = cur_ref;
      pos_d     = cur_pos;
      if (slot.last && cur_left) seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q     <= 1'b0;
      lr_prev_q <= 1'b0;
      ref_q     <= 1'b0;
      pos_q     <= POS_IDLE;
      seen_q    <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      bck_q     <= bck_d;
      lr_prev_q <= lr_prev_d;
      ref_q     <= ref_d;
      pos_q     <= pos_d;
      seen_q    <= seen_d;
      valid_q   <= valid_d;
    end
  end

  assign hit_o    = slot.hit;
  assign idx_o    = slot.idx;
  assign last_o   = slot.last;
  assign left_o   = cur_left;
  assign clr_o    = (cur_pos == '0);
  assign load_o   = fall_o & cur_left & (cur_pos == '0);
  assign commit_o = commit;
  assign valid_o  = valid_q;

  assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != POS_IDLE) |-> (pos_q < half_slots(wide)));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_valid_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(rise_o));
endmodule

// File: rtl/sap_rx_lane.sv
module sap_rx_lane
  import sap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                din,
  input  logic                rise,
  input  logic                hit,
  input  logic [4:0]          idx,
  input  logic                clr,
  input  logic                last,
  input  logic                left,
  input  logic                commit,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam logic [4:0] TOP = 5'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] acc_q, acc_d, acc_nx;
  logic [SAMPLE_W-1:0] stage_q, stage_d;
  logic [SAMPLE_W-1:0] outl_q, outl_d, outr_q, outr_d;

  always_comb begin
    acc_nx = clr ? '0 : acc_q;
    if (hit) acc_nx[TOP - idx] = din;
    acc_d   = rise ? acc_nx : acc_q;
    stage_d = (rise && last && left) ? acc_nx : stage_q;
    outl_d  = commit ? stage_q : outl_q;
    outr_d  = commit ? acc_nx  : outr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      stage_q <= '0;
      outl_q  <= '0;
      outr_q  <= '0;
    end else begin
      acc_q   <= acc_d;
      stage_q <= stage_d;
      outl_q  <= outl_d;
      outr_q  <= outr_d;
    end
  end

  assign left_o  = outl_q;
  assign right_o = outr_q;

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(outl_q) && $stable(outr_q)));
endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
  import sap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] l_i,
  input  logic [SAMPLE_W-1:0] r_i,
  input  logic                fall,
  input  logic                load,
  input  logic                hit,
  input  logic [4:0]          idx,
  input  logic                left,
  output logic                sdout_o
);
  localparam logic [4:0] TOP = 5'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d, word;
  logic                sd_q, sd_d;

  always_comb begin
    hold_l_d = load ? l_i : hold_l_q;
    hold_r_d = load ? r_i : hold_r_q;
    word     = left ? (load ? l_i : hold_l_q) : hold_r_q;
    sd_d     = sd_q;
    if (fall) sd_d = hit ? word[TOP - idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      sd_q     <= sd_d;
    end
  end

  assign sdout_o = sd_q;

  assert_launch_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sd_q));
endmodule

// File: rtl/sap_port.sv
module sap_port
  import sap_pkg::*;
#(
  parameter int LANES       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                cfg_fmt,
  input  logic [1:0]                cfg_wlen,
  input  logic                      cfg_wide,
  input  logic                      bck_i,
  input  logic                      lrck_i,
  input  logic [LANES-1:0]          sdin_i,
  input  logic [LANES*SAMPLE_W-1:0] tx_left_i,
  input  logic [LANES*SAMPLE_W-1:0] tx_right_i,
  output logic [LANES-1:0]          sdout_o,
  output logic [LANES*SAMPLE_W-1:0] rx_left_o,
  output logic [LANES*SAMPLE_W-1:0] rx_right_o,
  output logic                      rx_valid_o
);
  localparam int SYNC_W = LANES + 2;

  logic             rst_meta_q, rst_core_n;
  logic [SYNC_W-1:0] sync_q;
  logic             bck_s, lr_s;
  logic [LANES-1:0] din_s;
  logic             rise, fall, hit, last, left, clr, load, commit;
  logic [4:0]       idx;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  sap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({sdin_i, lrck_i, bck_i}),
    .q_o   (sync_q)
  );
  assign bck_s = sync_q[0];
  assign lr_s  = sync_q[1];
  assign din_s = sync_q[SYNC_W-1:2];

  sap_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bck_s    (bck_s),
    .lr_s     (lr_s),
    .fmt      (cfg_fmt),
    .wlen     (cfg_wlen),
    .wide     (cfg_wide),
    .rise_o   (rise),
    .fall_o   (fall),
    .hit_o    (hit),
    .idx_o    (idx),
    .last_o   (last),
    .left_o   (left),
    .clr_o    (clr),
    .load_o   (load),
    .commit_o (commit),
    .valid_o  (rx_valid_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sap_rx_lane u_rx (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .din     (din_s[g]),
      .rise    (rise),
      .hit     (hit),
      .idx     (idx),
      .clr     (clr),
      .last    (last),
      .left    (left),
      .commit  (commit),
      .left_o  (rx_left_o[g*SAMPLE_W +: SAMPLE_W]),
      .right_o (rx_right_o[g*SAMPLE_W +: SAMPLE_W])
    );

    sap_tx_lane u_tx (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .l_i     (tx_left_i[g*SAMPLE_W +: SAMPLE_W]),
      .r_i     (tx_right_i[g*SAMPLE_W +: SAMPLE_W]),
      .fall    (fall),
      .load    (load),
      .hit     (hit),
      .idx     (idx),
      .left    (left),
      .sdout_o (sdout_o[g])
    );

    assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
      rx_valid_o |-> (((rx_left_o[g*SAMPLE_W +: SAMPLE_W] | rx_right_o[g*SAMPLE_W +: SAMPLE_W])
                       & (24'hFF_FFFF >> word_bits(cfg_wlen, cfg_wide))) == '0));
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (!rx_valid_o && (sdout_o == '0)));
endmodule

// File: tb/sap_port_tb.sv
module sap_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int FR         = 3;
  localparam int LANES      = 3;

  logic                  clk, rst_n, cfg_wide, bck, lrck, rx_valid;
  logic [1:0]            cfg_fmt, cfg_wlen;
  logic [LANES-1:0]      sdin, sdout;
  logic [LANES*24-1:0]   txl_bus, txr_bus, rxl_bus, rxr_bus;

  int errors = 0;
  int checks = 0;
  int vcnt   = 0;
  int cur_fmt = 0;
  bit cur_wide = 1'b1;
  logic [23:0] el [FR][LANES];
  logic [23:0] er [FR][LANES];

  sap_port #(.LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_wide(cfg_wide),
    .bck_i(bck), .lrck_i(lrck), .sdin_i(sdin), .tx_left_i(txl_bus), .tx_right_i(txr_bus),
    .sdout_o(sdout), .rx_left_o(rxl_bus), .rx_right_o(rxr_bus), .rx_valid_o(rx_valid)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic string ftag(input int fmt, input bit wide);
    string t;
    t = (fmt == 0) ? "R3" : (fmt == 1) ? "R2" : "R4";
    if (!wide) t = {t, "/R6"};
    return t;
  endfunction

  function automatic int nbits(input logic [1:0] wl, input bit wide);
    if (!wide) return 16;
    case (wl)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  // Returns {in_word, bit} for absolute frame slot a (0 = first slot after left edge).
  function automatic logic [1:0] slot_bit(input int fmt, input bit wide, input int n, input int a,
                                          input logic [23:0] lw, input logic [23:0] rw,
                                          input logic [23:0] prw);
    int h, off, st, j;
    logic [23:0] w;
    h   = wide ? 32 : 16;
    off = (fmt == 0) ? 1 : (fmt == 2) ? h - n : 0;
    for (int ch = 0; ch < 2; ch++) begin
      st = ch * h + off;
      w  = (ch == 0) ? lw : ((a < st) ? prw : rw);
      j  = (a - st + 2*h) % (2*h);
      if (j < n) return {1'b1, w[23-j]};
    end
    return 2'b00;
  endfunction

  function automatic logic lr_level(input int fmt, input bit wide, input int a);
    bit lefth;
    lefth = (a < (wide ? 32 : 16));
    return (fmt == 0) ? !lefth : lefth;
  endfunction

  // R2 R3 R4 R5 R8 R9 R10: received frames against bench expectations
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (vcnt >= FR) begin
        errors++; checks++;
        $display("FAIL R9 extra strobe: got count %0d expected %0d", vcnt + 1, FR);
      end else begin
        for (int l = 0; l < LANES; l++) begin
          checks += 2;
          if (rxl_bus[l*24 +: 24] !== el[vcnt][l]) begin
            errors++;
            $display("FAIL %s/R5/R8/R10 rx left lane %0d frame %0d: got %h expected %h",
                     ftag(cur_fmt, cur_wide), l, vcnt, rxl_bus[l*24 +: 24], el[vcnt][l]);
          end
          if (rxr_bus[l*24 +: 24] !== er[vcnt][l]) begin
            errors++;
            $display("FAIL %s/R5/R8/R10 rx right lane %0d frame %0d: got %h expected %h",
                     ftag(cur_fmt, cur_wide), l, vcnt, rxr_bus[l*24 +: 24], er[vcnt][l]);
          end
        end
      end
      vcnt++;
    end
  end

  task automatic drive_slot(input logic lr, input logic [LANES-1:0] din,
                            input logic [LANES-1:0] exp_out, input bit chk);
    logic [LANES-1:0] got;
    @(negedge clk);
    bck = 1'b0; lrck = lr; sdin = din;
    repeat (HALF-1) @(negedge clk);
    got = sdout;
    if (chk) begin
      checks++;
      if (sdout !== exp_out) begin
        errors++;
        $display("FAIL %s/R7/R10 sdout: got %b expected %b", ftag(cur_fmt, cur_wide), sdout, exp_out);
      end
    end
    @(negedge clk);
    bck = 1'b1;
    repeat (HALF-1) @(negedge clk);
    if (chk) begin
      checks++;
      if (sdout !== got) begin
        errors++;
        $display("FAIL R11 sdout moved after rising edge: got %b expected %b", sdout, got);
      end
    end
  endtask

  task automatic run_cfg(input int fmt, input int wl, input bit wide);
    logic [23:0] txl [FR][LANES];
    logic [23:0] txr [FR][LANES];
    logic [23:0] rl  [FR][LANES];
    logic [23:0] rr  [FR][LANES];
    logic [23:0] mask, prv;
    logic [1:0]  sb;
    logic [LANES-1:0] din, eo;
    int n, h;
    n = nbits(wl[1:0], wide);
    h = wide ? 32 : 16;
    mask = 24'hFF_FFFF << (24 - n);
    cur_fmt = fmt; cur_wide = wide;
    cfg_fmt = fmt[1:0]; cfg_wlen = wl[1:0]; cfg_wide = wide;
    rst_n = 1'b0; bck = 1'b0; lrck = lr_level(fmt, wide, h); sdin = '0;
    txl_bus = '0; txr_bus = '0;
    repeat (4) @(negedge clk);
    // R1: quiet outputs under reset
    checks++;
    if (rx_valid !== 1'b0 || sdout !== '0 || rxl_bus !== '0 || rxr_bus !== '0) begin
      errors++;
      $display("FAIL R1 reset state: got valid=%b sdout=%b expected 0 0", rx_valid, sdout);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (rx_valid !== 1'b0 || sdout !== '0 || rxl_bus !== '0) begin
      errors++;
      $display("FAIL R1 after release: got valid=%b sdout=%b expected 0 0", rx_valid, sdout);
    end
    for (int k = 0; k < FR; k++)
      for (int l = 0; l < LANES; l++) begin
        txl[k][l] = 24'($urandom); txr[k][l] = 24'($urandom);
        rl[k][l]  = 24'($urandom); rr[k][l]  = 24'($urandom);
        el[k][l]  = rl[k][l] & mask; er[k][l] = rr[k][l] & mask;
      end
    // a few directed corner words on lane 0
    rl[0][0] = 24'h80_0001; el[0][0] = rl[0][0] & mask;
    rr[0][0] = 24'hFF_FFFF; er[0][0] = mask;
    txl[0][0] = 24'h00_0100; txr[0][0] = 24'hFF_FFFF;
    for (int l = 0; l < LANES; l++) begin
      txl_bus[l*24 +: 24] = txl[0][l];
      txr_bus[l*24 +: 24] = txr[0][l];
    end
    vcnt = 0;
    // warm-up slots at the right-channel level, random line data
    for (int s = 0; s < 4; s++)
      drive_slot(lr_level(fmt, wide, h), LANES'($urandom), '0, 1'b0);
    for (int k = 0; k < FR; k++) begin
      for (int a = 0; a < 2*h; a++) begin
        if (a == h && k + 1 < FR)
          for (int l = 0; l < LANES; l++) begin
            txl_bus[l*24 +: 24] = txl[k+1][l];
            txr_bus[l*24 +: 24] = txr[k+1][l];
          end
        for (int l = 0; l < LANES; l++) begin
          prv = (k > 0) ? rr[k-1][l] : 24'h0;
          sb = slot_bit(fmt, wide, n, a, rl[k][l], rr[k][l], prv);
          din[l] = sb[1] ? sb[0] : 1'($urandom);   // R8: garbage outside the word
          prv = (k > 0) ? txr[k-1][l] : 24'h0;
          sb = slot_bit(fmt, wide, n, a, txl[k][l], txr[k][l], prv);
          eo[l] = sb[1] & sb[0];                     // R7: zero outside the word
        end
        drive_slot(lr_level(fmt, wide, a), din, eo, 1'b1);
      end
    end
    for (int a = 0; a < 2; a++) begin
      for (int l = 0; l < LANES; l++) begin
        sb = slot_bit(fmt, wide, n, a, 24'h0, 24'h0, rr[FR-1][l]);
        din[l] = sb[1] & sb[0];
      end
      drive_slot(lr_level(fmt, wide, a), din, '0, 1'b0);
    end
    repeat (20) @(negedge clk);
    // R9: exactly one strobe per frame
    checks++;
    if (vcnt != FR) begin
      errors++;
      $display("FAIL R9 %s strobe count: got %0d expected %0d", ftag(fmt, wide), vcnt, FR);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h0000_5A17);
    rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; sdin = '0;
    cfg_fmt = '0; cfg_wlen = '0; cfg_wide = 1'b1; txl_bus = '0; txr_bus = '0;
    for (int f = 0; f < 3; f++) begin
      for (int w = 0; w < 4; w++) run_cfg(f, w, 1'b1);
      run_cfg(f, 3, 1'b0);   // R6: 32-slot frames force 16-bit words
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule